// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block turns the eight input pins of one general-purpose I/O port into a single interrupt request. Each pin is set up on its own: it either watches for a transition or watches a steady level. A transition watcher can react to rising edges, to falling edges, or to both. A level watcher reacts to a high or a low input. Pins that have seen a transition keep a pending flag until software acknowledges it. Pins that watch a level report the live input and keep nothing.

Software reaches the block through a small synchronous register port made of an address, a write strobe, write data and combinational read data. Four configuration registers choose the detection behaviour and which pins may interrupt. Two read-only views report the per-pin condition before and after masking. A write-one acknowledge register empties pending transition flags. The pins are brought into the clock domain by a two-stage synchroniser. Each pin then runs a small three-state machine: PIN_IDLE (transition mode, nothing pending), PIN_HELD (transition mode, flag pending) and PIN_LEVEL (level mode, no storage). The transitions are: IDLE→HELD on a matching transition; HELD→IDLE on an acknowledge when no new transition arrives in the same cycle; any state→LEVEL while the pin is in level mode; LEVEL→HELD or LEVEL→IDLE when level mode is left, depending on whether a matching transition is seen in that cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all four configuration registers read 0, no pin has a pending flag, every register address reads 0 and `irq_o` is low.
- R2: Address 0 holds the per-pin mode bits (1 = level, 0 = transition), address 1 holds the any-transition bits, address 2 holds the polarity bits and address 3 holds the mask. All four read back what was written. Address 4 (raw condition) and address 5 (masked condition) are read-only, and writes to them change nothing. Address 6 (acknowledge) is write-only and reads 0.
- R3: A pin value sampled at a rising clock edge is seen by the detection logic at the next edge. A level-mode pin's raw bit shows that value after the second edge. A transition-mode pin's flag is set after the third edge.
- R4: With the any-transition bit clear, polarity 0 selects falling transitions and polarity 1 selects rising transitions. A transition of the other direction sets no flag.
- R5: With the any-transition bit set, both rising and falling transitions set the flag, whatever the polarity bit holds. The any-transition bit has no effect in level mode.
- R6: In level mode the raw bit equals the synchronised input (polarity 1) or its inverse (polarity 0). It drops as soon as the active level goes away, with no latch and no acknowledge needed.
- R7: The raw bit does not depend on the mask. The masked view is raw AND mask, and `irq_o` is high exactly when any masked bit is 1.
- R8: A transition flag stays set until a write to address 6 has a 1 in that pin's bit. Zero bits in that write leave flags unchanged.
- R9: If a matching transition and an acknowledge for the same pin fall in the same cycle, the flag stays set.
- R10: A configuration write that makes a level condition true shows at once in the raw view, and on `irq_o` if the pin is unmasked, starting in the cycle after the write.
- R11: Putting a pin into level mode drops any pending transition flag, so the flag does not come back when the pin returns to transition mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pin_i | input | 8 | Asynchronous port pin inputs |
| irq_o | output | 1 | Port interrupt request |

## Verification
Two functions can meet in one cycle: a newly detected transition and a software acknowledge for the same pin. The bench changes the pin, waits exactly the two synchroniser edges, and issues the acknowledge write so that it is sampled at the edge where the transition is detected. The flag must then still read set, while an acknowledge with no new transition must clear it. A second overlap is a configuration write that lands while the pin already holds the selected level. That write must raise the raw bit and the interrupt in the very next cycle. A behavioural model compares both read data and the interrupt on every clock, including during a long mixed random run.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_MODE   = 3'd0,
        REG_ANYEDG = 3'd1,
        REG_POL    = 3'd2,
        REG_MASK   = 3'd3,
        REG_RAW    = 3'd4,
        REG_MSKD   = 3'd5,
        REG_ACK    = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        PIN_IDLE  = 2'b00,
        PIN_HELD  = 2'b01,
        PIN_LEVEL = 2'b10
    } pin_state_e;

    typedef struct packed {
        logic level_mode;
        logic any_edge;
        logic pol_high;
    } pin_cfg_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] cur_o,
    output logic [NPINS-1:0] prv_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [NPINS-1:0] stage_q [STAGES];
    logic [NPINS-1:0] prv_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= pin_i;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prv_q <= '0;
        end else begin
            prv_q <= stage_q[LAST];
        end
    end

    assign cur_o = stage_q[LAST];
    assign prv_o = prv_q;

endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [REG_AW-1:0] addr_i,
    input  logic              we_i,
    input  logic [NPINS-1:0]  wdata_i,
    input  logic [NPINS-1:0]  raw_i,
    input  logic [NPINS-1:0]  masked_i,
    output logic [NPINS-1:0]  mode_o,
    output logic [NPINS-1:0]  anyedg_o,
    output logic [NPINS-1:0]  pol_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  ack_o,
    output logic [NPINS-1:0]  rdata_o
);

    logic [NPINS-1:0] mode_q;
    logic [NPINS-1:0] anyedg_q;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] mask_q;
    reg_addr_e        sel;

    assign sel = reg_addr_e'(addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q   <= '0;
            anyedg_q <= '0;
            pol_q    <= '0;
            mask_q   <= '0;
        end else if (we_i) begin
            unique case (sel)
                REG_MODE:   mode_q   <= wdata_i;
                REG_ANYEDG: anyedg_q <= wdata_i;
                REG_POL:    pol_q    <= wdata_i;
                REG_MASK:   mask_q   <= wdata_i;
                default:    ;
            endcase
        end
    end

    always_comb begin
        ack_o = '0;
        if (we_i && (sel == REG_ACK)) begin
            ack_o = wdata_i;
        end
    end

    always_comb begin
        unique case (sel)
            REG_MODE:   rdata_o = mode_q;
            REG_ANYEDG: rdata_o = anyedg_q;
            REG_POL:    rdata_o = pol_q;
            REG_MASK:   rdata_o = mask_q;
            REG_RAW:    rdata_o = raw_i;
            REG_MSKD:   rdata_o = masked_i;
            default:    rdata_o = '0;
        endcase
    end

    assign mode_o   = mode_q;
    assign anyedg_o = anyedg_q;
    assign pol_o    = pol_q;
    assign mask_o   = mask_q;

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  pin_cfg_t cfg_i,
    input  logic     cur_i,
    input  logic     prv_i,
    input  logic     ack_i,
    output logic     raw_o
);

    pin_state_e state_q;
    pin_state_e state_d;
    logic       rise;
    logic       fall;
    logic       edge_hit;
    logic       level_hit;

    always_comb begin
        rise      = cur_i & ~prv_i;
        fall      = ~cur_i & prv_i;
        edge_hit  = cfg_i.any_edge ? (rise | fall)
                                   : (cfg_i.pol_high ? rise : fall);
        level_hit = cfg_i.pol_high ? cur_i : ~cur_i;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE: begin
                if (cfg_i.level_mode)  state_d = PIN_LEVEL;
                else if (edge_hit)     state_d = PIN_HELD;
            end
            PIN_HELD: begin
                if (cfg_i.level_mode)        state_d = PIN_LEVEL;
                else if (ack_i && !edge_hit) state_d = PIN_IDLE;
            end
            PIN_LEVEL: begin
                if (!cfg_i.level_mode) begin
                    state_d = edge_hit ? PIN_HELD : PIN_IDLE;
                end
            end
            default: state_d = PIN_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PIN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output logic
    always_comb begin
        if (cfg_i.level_mode) begin
            raw_o = level_hit;
        end else begin
            unique case (state_q)
                PIN_HELD: raw_o = 1'b1;
                default:  raw_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS     = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [REG_AW-1:0] addr_i,
    input  logic              we_i,
    input  logic [NPINS-1:0]  wdata_i,
    output logic [NPINS-1:0]  rdata_o,
    input  logic [NPINS-1:0]  pin_i,
    output logic              irq_o
);

    logic [NPINS-1:0] cur_w;
    logic [NPINS-1:0] prv_w;
    logic [NPINS-1:0] mode_w;
    logic [NPINS-1:0] anyedg_w;
    logic [NPINS-1:0] pol_w;
    logic [NPINS-1:0] mask_w;
    logic [NPINS-1:0] ack_w;
    logic [NPINS-1:0] raw_w;
    logic [NPINS-1:0] masked_w;

    gpio_irq_sync #(
        .NPINS (NPINS),
        .STAGES(SYNC_DEPTH)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (pin_i),
        .cur_o (cur_w),
        .prv_o (prv_w)
    );

    gpio_irq_cfg #(
        .NPINS(NPINS)
    ) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (addr_i),
        .we_i    (we_i),
        .wdata_i (wdata_i),
        .raw_i   (raw_w),
        .masked_i(masked_w),
        .mode_o  (mode_w),
        .anyedg_o(anyedg_w),
        .pol_o   (pol_w),
        .mask_o  (mask_w),
        .ack_o   (ack_w),
        .rdata_o (rdata_o)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg = '{level_mode: mode_w[p], any_edge: anyedg_w[p], pol_high: pol_w[p]};

        gpio_irq_pin u_pin (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .cfg_i (cfg),
            .cur_i (cur_w[p]),
            .prv_i (prv_w[p]),
            .ack_i (ack_w[p]),
            .raw_o (raw_w[p])
        );
    end

    assign masked_w = raw_w & mask_w;
    assign irq_o    = |masked_w;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [REG_AW-1:0] addr_i,
    input logic              we_i,
    input logic [NPINS-1:0]  wdata_i,
    input logic [NPINS-1:0]  rdata_o,
    input logic              irq_o,
    input logic [NPINS-1:0]  raw_i,
    input logic [NPINS-1:0]  mask_i,
    input logic [NPINS-1:0]  mode_i
);

    AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == REG_MASK) |=> (mask_i == $past(wdata_i))); // R2

    AST_ACK_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == REG_ACK) |-> (rdata_o == '0)); // R2

    AST_IRQ_MATCHES_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == REG_MSKD) |-> (irq_o == (rdata_o != '0))); // R7

    for (genvar p = 0; p < NPINS; p++) begin : g_chk
        AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!mode_i[p] && raw_i[p]
             && !(we_i && addr_i == REG_ACK && wdata_i[p])
             && !(we_i && addr_i == REG_MODE && wdata_i[p]))
            |=> raw_i[p]); // R8

        AST_LEVEL_EMPTIES_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(mode_i[p]) |-> !raw_i[p]); // R11
    end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o),
    .raw_i  (raw_w),
    .mask_i (mask_w),
    .mode_i (mode_w)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic         we = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] pin = '0;
    logic [N-1:0] rdata;
    logic         irq;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .addr_i (addr),
        .we_i   (we),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .pin_i  (pin),
        .irq_o  (irq)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    // Behavioural reference model
    logic [N-1:0] m_mode = '0, m_any = '0, m_pol = '0, m_mask = '0, m_flag = '0;
    logic [N-1:0] hist[$];

    function automatic logic [N-1:0] seen(int ago);
        return (hist.size() > ago) ? hist[ago] : '0;
    endfunction

    function automatic logic [N-1:0] m_raw();
        logic [N-1:0] s  = seen(1);
        logic [N-1:0] lv = (m_pol & s) | (~m_pol & ~s);
        return (m_mode & lv) | (~m_mode & m_flag);
    endfunction

    function automatic logic [N-1:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_any;
            3'd2: return m_pol;
            3'd3: return m_mask;
            3'd4: return m_raw();
            3'd5: return m_raw() & m_mask;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = '0; m_any = '0; m_pol = '0; m_mask = '0; m_flag = '0;
            hist.delete();
        end else begin
            logic [N-1:0] c, p, rise, fall, hit, ack;
            c    = seen(1);
            p    = seen(2);
            rise = c & ~p;
            fall = ~c & p;
            hit  = (m_any & (rise | fall)) | (~m_any & m_pol & rise) | (~m_any & ~m_pol & fall);
            ack  = (we && addr == 3'd6) ? wdata : '0;
            m_flag = ~m_mode & (hit | (m_flag & ~ack));
            if (we) begin
                case (addr)
                    3'd0: m_mode = wdata;
                    3'd1: m_any  = wdata;
                    3'd2: m_pol  = wdata;
                    3'd3: m_mask = wdata;
                    default: ;
                endcase
            end
            hist.push_front(pin);
            if (hist.size() > 3) void'(hist.pop_back());
        end
    end

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            check(phase, rdata, m_read(addr));
            check(phase, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_raw() & m_mask)});
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [N-1:0] d);
        cyc();
        addr = a; we = 1'b1; wdata = d;
        cyc();
        we = 1'b0; wdata = '0;
    endtask

    task automatic peek(string tag, logic [2:0] a, logic [N-1:0] exp);
        cyc();
        addr = a; we = 1'b0;
        @(negedge clk);
        check(tag, rdata, exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        phase = "R1";
        idle(3);
        for (int a = 0; a < 7; a++) peek("R1", 3'(a), '0);
        check("R1", {{(N-1){1'b0}}, irq}, '0);
        cyc();
        rst_n = 1'b1;
        idle(2);

        // R2: register access
        phase = "R2";
        wr(3'd0, 8'hA5); peek("R2", 3'd0, 8'hA5);
        wr(3'd1, 8'h3C); peek("R2", 3'd1, 8'h3C);
        wr(3'd2, 8'hC3); peek("R2", 3'd2, 8'hC3);
        wr(3'd3, 8'h5A); peek("R2", 3'd3, 8'h5A);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd4, 8'hFF); peek("R2", 3'd4, 8'h00);
        wr(3'd5, 8'hFF); peek("R2", 3'd5, 8'h00);
        peek("R2", 3'd6, 8'h00);

        // R4: default falling-edge mode; R7 raw independent of mask
        phase = "R4";
        cyc(); pin = 8'hFF; idle(4);
        peek("R4", 3'd4, 8'h00);
        cyc(); pin = 8'hFE; idle(4);
        peek("R4", 3'd4, 8'h01);
        phase = "R7";
        check("R7", {{(N-1){1'b0}}, irq}, '0);
        wr(3'd3, 8'h01);
        peek("R7", 3'd5, 8'h01);
        check("R7", {{(N-1){1'b0}}, irq}, 8'h01);

        // R8: acknowledge semantics
        phase = "R8";
        wr(3'd6, 8'hFE); peek("R8", 3'd4, 8'h01);
        wr(3'd6, 8'h01); peek("R8", 3'd4, 8'h00);

        // R4: rising polarity, falling ignored
        phase = "R4";
        wr(3'd2, 8'h02);
        cyc(); pin = 8'hFC; idle(4);
        peek("R4", 3'd4, 8'h00);
        cyc(); pin = 8'hFE; idle(4);
        peek("R4", 3'd4, 8'h02);
        wr(3'd6, 8'h02);

        // R5: both edges
        phase = "R5";
        wr(3'd1, 8'h04);
        cyc(); pin = 8'hFA; idle(4);
        peek("R5", 3'd4, 8'h04);
        wr(3'd6, 8'h04); peek("R5", 3'd4, 8'h00);
        cyc(); pin = 8'hFE; idle(4);
        peek("R5", 3'd4, 8'h04);
        wr(3'd6, 8'h04);

        // R3: level latency (sense and polarity for pin 5, pin 5 low)
        phase = "R3";
        wr(3'd2, 8'h22);
        wr(3'd0, 8'h20);
        cyc(); addr = 3'd4; pin = 8'hDE;   // pin 5 low, mode bit 5 level-high
        @(negedge clk); check("R3", rdata[5] ? 8'h20 : 8'h00, 8'h20);
        cyc(); @(negedge clk); check("R3", rdata & 8'h20, 8'h20);
        cyc(); @(negedge clk); check("R3", rdata & 8'h20, 8'h00);

        // R6: level follows input, no latch
        phase = "R6";
        cyc(); pin = 8'hFE; idle(3);
        peek("R6", 3'd4, 8'h20);
        cyc(); pin = 8'hDE; idle(3);
        peek("R6", 3'd4, 8'h00);
        wr(3'd2, 8'h02);
        peek("R6", 3'd4, 8'h20);
        wr(3'd0, 8'h00);

        // R10: spurious condition from a config write
        phase = "R10";
        wr(3'd3, 8'h08);
        wr(3'd2, 8'h0A);
        cyc(); addr = 3'd0; we = 1'b1; wdata = 8'h08;
        cyc(); we = 1'b0; wdata = '0; addr = 3'd5;
        @(negedge clk);
        check("R10", {{(N-1){1'b0}}, irq}, 8'h01);
        check("R10", rdata, 8'h08);

        // R11: level mode drops a pending flag
        phase = "R11";
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h00);
        cyc(); pin = 8'hCE; idle(4);   // pin 4 falls
        peek("R11", 3'd4, 8'h10);
        wr(3'd0, 8'h10); wr(3'd2, 8'h10); wr(3'd0, 8'h00);
        peek("R11", 3'd4, 8'h00);

        // R9: transition and acknowledge in the same cycle
        phase = "R9";
        cyc(); pin = 8'hDE; idle(4);
        wr(3'd2, 8'h10);
        cyc(); pin = 8'hCE;            // change sampled at next edge
        cyc();
        cyc(); addr = 3'd6; we = 1'b1; wdata = 8'h10;
        cyc(); we = 1'b0; wdata = '0;
        peek("R9", 3'd4, 8'h00);       // pin 4 fell, rising selected: nothing
        cyc(); pin = 8'hDE;
        cyc();
        cyc(); addr = 3'd6; we = 1'b1; wdata = 8'h10;
        cyc(); we = 1'b0; wdata = '0;
        peek("R9", 3'd4, 8'h10);       // edge won over acknowledge
        wr(3'd6, 8'h10);
        peek("R9", 3'd4, 8'h00);

        // Mixed pseudo-random run, checked every cycle by the model
        phase = "R7";
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                cyc();
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                pin  = lfsr[7:0] ^ lfsr[15:8];
                we   = (lfsr[3:0] < 4'd5);
                addr = 3'(lfsr[10:8] % 7);
                wdata = lfsr[15:8];
            end
            cyc(); we = 1'b0;
        end
        idle(4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule